// File: doc/BRIEF.md
# Terminal Clock Generator with Cycle Stretch

This block derives every timing signal of a video terminal from one master dot clock. The master clock itself drives the pixel shift register, so the block gives a shift enable that is high on every master cycle once reset is released. One free-running counter divides the master clock by 13 and issues a one-cycle baud reference pulse for the serial ports. A second counter divides by 14 and gives the character clock for the display controller.

The processor phase-2 clock comes from the same divide-by-14 counter. It is the inverse of the character clock, so the processor and the display controller reach the shared memory on alternate half-cycles. A requester that needs a slow access raises a stretch request. The block samples that request only on the last master cycle of a processor cycle. When it sees the request, the next processor cycle lasts 28 master cycles instead of 14: the first 14 with the phase clock low and the last 14 with it high. Because a stretched cycle covers exactly two character periods, the phase clock is again opposite to the character clock when the stretched cycle ends. A flag stays high for the whole doubled cycle.

Top module: `tc_clockgen`

## Requirements
- R1: `dot_en` is low while `rst` is high and is high on every master cycle after reset is released.
- R2: `baud_en` is high for exactly one master cycle in every 13. Counting the first rising edge after reset release as edge 1, the first pulse is visible after edge 12.
- R3: `char_clk` has a period of 14 master cycles. Starting from reset it is high for 7 cycles and then low for 7 cycles.
- R4: When no stretched cycle is in progress, `cpu_clk` is the inverse of `char_clk`.
- R5: `stretch_req` is sampled only on the master cycle in which the character count is at its last value (13). This is the final cycle of a processor cycle. A request on any other cycle has no effect on `cpu_clk` or `stretch_active`.
- R6: A sampled request makes the next processor cycle 28 master cycles long. `cpu_clk` is low for the first 14 cycles and high for the last 14. `stretch_active` is high for all 28 cycles.
- R7: A request during the first half of a stretched cycle is ignored. A request sampled on the final cycle of a stretched cycle starts another stretched cycle directly after it, so a held request gives back-to-back stretches.
- R8: When a stretched cycle ends, `cpu_clk` is again the inverse of `char_clk` from its first master cycle on.
- R9: While `rst` is high, all counters are cleared synchronously. The outputs are then `baud_en`=0, `char_clk`=1, `cpu_clk`=0, `stretch_active`=0 and `dot_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master dot clock |
| rst | input | 1 | Synchronous reset, active high |
| stretch_req | input | 1 | Asks for the next processor cycle to be doubled |
| dot_en | output | 1 | Pixel shift enable at the master rate |
| baud_en | output | 1 | One-cycle pulse every 13 master cycles |
| char_clk | output | 1 | Character clock for the display controller, master/14 |
| cpu_clk | output | 1 | Processor phase-2 clock, opposite to char_clk outside stretches |
| stretch_active | output | 1 | High for the whole of a doubled processor cycle |

## Verification
The divide-by-13 and divide-by-14 counters share no common factor. Over time, a baud pulse therefore lands on every character count, including the last cycle of a stretched processor cycle, where the stretch machine either hands back to normal phasing or starts the next stretch. The bench drives a request exactly on that last cycle, holds the request high for many cycles, and also runs a long random stretch sequence. In all of these it compares every output against a model built from elapsed-cycle arithmetic on every master cycle. Requests placed away from the cycle boundary, and requests inside the low half of a stretch, are judged by the next cycles of `stretch_active` and `cpu_clk`: both must follow the unchanged model.

// File: rtl/tclk_pkg.sv
package tclk_pkg;
  // phase of the processor clock sequencer
  typedef enum logic [1:0] {
    PH_NORMAL  = 2'd0,
    PH_LONG_LO = 2'd1,
    PH_LONG_HI = 2'd2
  } cyc_phase_e;

  localparam int unsigned DEF_BAUD_DIV = 13;
  localparam int unsigned DEF_CHAR_DIV = 14;
endpackage

// File: rtl/tc_mod_div.sv
module tc_mod_div #(
  parameter int unsigned DIV = 14,
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output logic          at_last
);
  function automatic logic is_last(input logic [CW-1:0] c);
    return c == CW'(DIV - 1);
  endfunction

  assign at_last = is_last(cnt);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (at_last) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    at_last |=> cnt == '0);

  // R3
  in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DIV - 1));
endmodule

// File: rtl/tc_stretch_fsm.sv
module tc_stretch_fsm
  import tclk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cyc_last,
  input  logic char_hi,
  input  logic req,
  output logic cpu_clk,
  output logic active
);
  cyc_phase_e phase, phase_nx;

  always_comb begin
    phase_nx = phase;
    if (cyc_last) begin
      unique case (phase)
        PH_LONG_LO: phase_nx = PH_LONG_HI;
        default:    phase_nx = req ? PH_LONG_LO : PH_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_NORMAL;
    else     phase <= phase_nx;
  end

  always_comb begin
    unique case (phase)
      PH_LONG_LO: cpu_clk = 1'b0;
      PH_LONG_HI: cpu_clk = 1'b1;
      default:    cpu_clk = ~char_hi;
    endcase
  end

  assign active = (phase != PH_NORMAL);

  // R7
  lo_then_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LONG_LO && cyc_last) |=> phase == PH_LONG_HI);

  // R5
  hold_mid_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_last |=> $stable(phase));
endmodule

// File: rtl/tc_clockgen.sv
module tc_clockgen
  import tclk_pkg::*;
#(
  parameter int unsigned BAUD_DIV = DEF_BAUD_DIV,
  parameter int unsigned CHAR_DIV = DEF_CHAR_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic stretch_req,
  output logic dot_en,
  output logic baud_en,
  output logic char_clk,
  output logic cpu_clk,
  output logic stretch_active
);
  localparam int unsigned BW   = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int unsigned CCW  = (CHAR_DIV > 1) ? $clog2(CHAR_DIV) : 1;
  localparam int unsigned HALF = CHAR_DIV / 2;

  function automatic logic char_high(input logic [CCW-1:0] c);
    return c < CCW'(HALF);
  endfunction

  logic [BW-1:0]  baud_cnt;
  logic [CCW-1:0] char_cnt;
  logic           baud_last;
  logic           char_last;
  logic           char_hi;
  logic           dot_q;

  tc_mod_div #(.DIV(BAUD_DIV)) u_baud_div (
    .clk(clk), .rst(rst), .cnt(baud_cnt), .at_last(baud_last)
  );

  tc_mod_div #(.DIV(CHAR_DIV)) u_char_div (
    .clk(clk), .rst(rst), .cnt(char_cnt), .at_last(char_last)
  );

  assign char_hi = char_high(char_cnt);

  tc_stretch_fsm u_fsm (
    .clk(clk), .rst(rst), .cyc_last(char_last), .char_hi(char_hi),
    .req(stretch_req), .cpu_clk(cpu_clk), .active(stretch_active)
  );

  always_ff @(posedge clk) begin
    if (rst) dot_q <= 1'b0;
    else     dot_q <= 1'b1;
  end

  assign dot_en   = dot_q;
  assign baud_en  = baud_last;
  assign char_clk = char_hi;

  // R2
  baud_single_chk: assert property (@(posedge clk) disable iff (rst)
    baud_en |=> !baud_en);

  // R2
  baud_restart_chk: assert property (@(posedge clk) disable iff (rst)
    baud_en |=> baud_cnt == '0);

  // R4
  opposite_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !stretch_active |-> cpu_clk != char_clk);

  // R5
  stretch_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stretch_active) |-> (char_cnt == '0 && !cpu_clk));

  // R8
  realign_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stretch_active) |-> (char_cnt == '0 && cpu_clk != char_clk));

  // R1
  dot_run_chk: assert property (@(posedge clk) disable iff (rst)
    dot_en |=> dot_en);
endmodule

// File: tb/tb_tc_clockgen.sv
module tb_tc_clockgen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stretch_req = 1'b0;
  logic dot_en, baud_en, char_clk, cpu_clk, stretch_active;

  always #2 clk = ~clk;

  tc_clockgen dut (
    .clk(clk), .rst(rst), .stretch_req(stretch_req), .dot_en(dot_en),
    .baud_en(baud_en), .char_clk(char_clk), .cpu_clk(cpu_clk),
    .stretch_active(stretch_active)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model: elapsed cycles since reset release plus a stretch phase
  int t = 0;
  int m_ch = 0;
  int m_b = 0;
  int ms = 0;            // 0 normal, 1 stretched low half, 2 stretched high half
  int since_stretch = 1000;

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0d", tag, what, act, exp, t);
    end
  endtask

  task automatic model_step(input logic req);
    if (m_ch == 13) begin
      if (ms == 1) ms = 2;
      else begin
        if (ms == 2) since_stretch = 0;
        ms = req ? 1 : 0;
      end
    end
    if (ms == 0 && since_stretch < 1000) since_stretch++;
    t++;
    m_ch = t % 14;
    m_b = t % 13;
  endtask

  task automatic compare(input string ptag);
    string ctag;
    logic exp_char;
    logic exp_cpu;
    exp_char = (m_ch < 7);
    exp_cpu = (ms == 1) ? 1'b0 : (ms == 2) ? 1'b1 : ~exp_char;
    if (ptag != "") ctag = ptag;
    else if (ms != 0) ctag = "R6";
    else if (since_stretch <= 14) ctag = "R8";
    else ctag = "R4";
    chk(dot_en, 1'b1, "R1", "dot_en");
    chk(baud_en, (m_b == 12), "R2", "baud_en");
    chk(char_clk, exp_char, "R3", "char_clk");
    chk(cpu_clk, exp_cpu, ctag, "cpu_clk");
    chk(stretch_active, (ms != 0), (ptag != "") ? ptag : "R6", "stretch_active");
  endtask

  task automatic run_cycle(input logic req, input string ptag);
    stretch_req = req;
    @(posedge clk);
    model_step(req);
    @(negedge clk);
    compare(ptag);
  endtask

  task automatic go_to_last(input string ptag);
    while (m_ch != 13) run_cycle(1'b0, ptag);
  endtask

  always @(posedge clk) begin
    if (!done && $time > 600000) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(dot_en, 1'b0, "R9", "dot_en in reset");
    chk(baud_en, 1'b0, "R9", "baud_en in reset");
    chk(char_clk, 1'b1, "R9", "char_clk in reset");
    chk(cpu_clk, 1'b0, "R9", "cpu_clk in reset");
    chk(stretch_active, 1'b0, "R9", "stretch_active in reset");
    rst = 1'b0;

    // R2 R3 R4 free running
    for (int i = 0; i < 200; i++) run_cycle(1'b0, "");

    // R5 request away from the cycle boundary is ignored
    while (m_ch != 5) run_cycle(1'b0, "R5");
    run_cycle(1'b1, "R5");
    for (int i = 0; i < 30; i++) run_cycle(1'b0, "R5");

    // R6 R8 single stretch
    go_to_last("");
    run_cycle(1'b1, "");
    for (int i = 0; i < 60; i++) run_cycle(1'b0, "");

    // R7 request in the low half of a stretch is ignored
    go_to_last("");
    run_cycle(1'b1, "");
    go_to_last("R7");
    run_cycle(1'b1, "R7");
    for (int i = 0; i < 40; i++) run_cycle(1'b0, "");

    // R7 held request gives back-to-back stretches
    for (int i = 0; i < 150; i++) run_cycle(1'b1, "");
    for (int i = 0; i < 60; i++) run_cycle(1'b0, "");

    // mixed random pattern, baud pulses fall on every stretch boundary
    for (int i = 0; i < 4000; i++) run_cycle(($urandom_range(0, 3) == 0), "");

    // R9 reset mid stretch clears everything
    go_to_last("");
    run_cycle(1'b1, "");
    run_cycle(1'b0, "");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(stretch_active, 1'b0, "R9", "stretch_active after reset");
    chk(char_clk, 1'b1, "R9", "char_clk after reset");
    chk(cpu_clk, 1'b0, "R9", "cpu_clk after reset");
    chk(baud_en, 1'b0, "R9", "baud_en after reset");
    chk(dot_en, 1'b0, "R9", "dot_en after reset");
    t = 0; m_ch = 0; m_b = 0; ms = 0; since_stretch = 1000;
    rst = 1'b0;
    for (int i = 0; i < 40; i++) run_cycle(1'b0, "");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule